// File: doc/BRIEF.md
# DMA Transfer Request Generator with Bandwidth Throttle

This block decides, on every clock, whether one DMA channel should be asking for the system bus and whether a data transfer may take place in the current cycle. Software arms the channel with a start bit. Along with the start bit it supplies a request mode and, for the throttled mode, a bandwidth code. The block then raises a bus request. When the bus is owned, it also raises a per-cycle transfer strobe. Both stay up until the start bit is cleared or the transfer-complete input fires.

There are three request modes. In full-rate mode the channel asks for every cycle. In limited-rate mode a 1024-clock window repeats, and requests are allowed only in the first part of each window. In external mode a device request pin paces the requests after a two-flop synchronizer. In every mode a competing bus master, or an interrupt when interrupt preemption is enabled, withdraws the request in the same cycle. Arbitration, address and count registers, and bus-cycle sequencing are handled elsewhere.

Top module: `dma_req_gen`

## Requirements
- R1: After reset, and whenever the start bit has never been raised, `bus_req_o` and `xfer_ok_o` are 0.
- R2: `xfer_ok_o` is 1 exactly when `bus_req_o` is 1 and `bus_owned_i` is 1.
- R3: With mode 00 (full rate) captured, `bus_req_o` is 1 on every clock from the first edge that samples the start bit high, unless preempted.
- R4: `bus_req_o` is 0 in any cycle in which `ext_master_req_i` is 1, or in which `irq_pending_i` and `irq_preempt_en_i` are both 1. A pending interrupt with the enable at 0 has no effect.
- R5: With mode 01 (limited rate) captured, number the active cycles k from 0 at the first edge that samples the start bit high. `bus_req_o` may be 1 only when (k mod 1024) < N. N is 128, 256, 512 or 768 for bandwidth codes 00, 01, 10 and 11.
- R6: The limited-rate window keeps counting while the request is preempted or the bus is not owned, so the allotment never moves to later clocks.
- R7: With mode 10 (external) captured, `bus_req_o` equals the value `ext_req_i` had two clock edges earlier.
- R8: Mode and bandwidth code are captured on the rising edge of the start bit. Later changes to `mode_i` or `bw_code_i` have no effect on the running request.
- R9: After an edge that samples the start bit low, or that samples `xfer_done_i` high, `bus_req_o` is 0. After completion it stays 0 until the start bit is cleared and set again, and the window then restarts at zero.
- R10: Mode 11 is reserved and never produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Channel start bit |
| mode_i | input | 2 | Request mode: 00 full, 01 limited, 10 external, 11 reserved |
| bw_code_i | input | 2 | Bandwidth code for limited mode |
| ext_req_i | input | 1 | Asynchronous device request |
| ext_master_req_i | input | 1 | Another master wants the bus |
| irq_pending_i | input | 1 | Unmasked interrupt pending |
| irq_preempt_en_i | input | 1 | Interrupt preemption enable |
| bus_owned_i | input | 1 | Channel currently owns the bus |
| xfer_done_i | input | 1 | Transfer count exhausted |
| bus_req_o | output | 1 | Bus request |
| xfer_ok_o | output | 1 | Transfer allowed this cycle |

## Verification
Every bandwidth code is swept over slightly more than two whole windows. This shows the boundary at clock N, the reopening at clock 1024, and the difference between the four allotments. The same sweeps are repeated with periodic preemption, periodic loss of bus ownership and a mid-run change of code. These runs separate a window that keeps counting from one that stalls, and a captured code from a live one. Full-rate runs combine external-master and interrupt preemption with the enable both off and on. A pseudo-random device request pattern in external mode pins down the two-clock latency. Stop, completion, restart and reserved-mode runs check that the request falls one clock after each event.

// File: rtl/dma_req_pkg.sv
// Package: shared mode encoding and window allotment helper for the
// DMA request generator. Assumes a window length divisible by 8.
package dma_req_pkg;

    typedef enum logic [1:0] {
        REQ_FULL  = 2'b00,
        REQ_LIMIT = 2'b01,
        REQ_EXT   = 2'b10,
        REQ_NONE  = 2'b11
    } req_mode_e;

    // Number of eighths of the window allotted to a bandwidth code.
    function automatic int unsigned bw_eighths(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
// Module: multi-flop synchronizer for an asynchronous level input.
// Assumes the input is a slow level; no pulse stretching is done.
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dma_req_ctrl.sv
// Module: start-bit tracking and configuration capture. Detects the
// rising edge of the start bit, latches mode and bandwidth code on it,
// and keeps an active flag until start is cleared or the transfer ends.
// Assumes start_i is a synchronous register bit.
module dma_req_ctrl
    import dma_req_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      done_i,
    input  logic [1:0] mode_i,
    input  logic [1:0] bw_code_i,
    output logic      active_o,
    output req_mode_e mode_o,
    output logic [1:0] bw_code_o
);
    logic      start_q;
    logic      active_q;
    logic      start_rise;
    logic      active_d;
    req_mode_e mode_q;
    logic [1:0] bw_q;

    // Edge detect and next active state.
    always_comb begin
        start_rise = start_i & ~start_q;
        active_d   = start_i & ~done_i & (active_q | start_rise);
    end

    // Register the start level and the active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            active_q <= 1'b0;
        end else begin
            start_q  <= start_i;
            active_q <= active_d;
        end
    end

    // Capture configuration on the start edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= REQ_NONE;
            bw_q   <= 2'b00;
        end else if (start_rise) begin
            mode_q <= req_mode_e'(mode_i);
            bw_q   <= bw_code_i;
        end
    end

    assign active_o  = active_q;
    assign mode_o    = mode_q;
    assign bw_code_o = bw_q;
endmodule

// File: rtl/dma_req_window.sv
// Module: bandwidth window. Counts active clocks modulo WINDOW_LEN and
// opens the request gate for the first allotment of each window.
// Assumes WINDOW_LEN is a power of two, divisible by 8.
module dma_req_window
    import dma_req_pkg::*;
#(
    parameter int WINDOW_LEN = 1024,
    localparam int CNT_W     = $clog2(WINDOW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [1:0]       bw_code_i,
    output logic             open_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int EIGHTH = WINDOW_LEN / 8;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   limit;

    // Advance the window position while running, else hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)  cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    // Allotment for the captured code and the open comparison.
    always_comb begin
        limit  = (CNT_W+1)'(EIGHTH * bw_eighths(bw_code_i));
        open_o = ({1'b0, cnt_q} < limit);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_req_gen.sv
// Module: DMA transfer request generator (top). Combines the captured
// mode with the window gate, the synchronized device request and the
// preemption inputs into a bus request and a per-cycle transfer strobe.
// Assumes preemption inputs are synchronous to clk.
module dma_req_gen
    import dma_req_pkg::*;
#(
    parameter int WINDOW_LEN  = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(WINDOW_LEN)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic [1:0] bw_code_i,
    input  logic       ext_req_i,
    input  logic       ext_master_req_i,
    input  logic       irq_pending_i,
    input  logic       irq_preempt_en_i,
    input  logic       bus_owned_i,
    input  logic       xfer_done_i,
    output logic       bus_req_o,
    output logic       xfer_ok_o
);
    logic             active;
    req_mode_e        mode_q;
    logic [1:0]       bw_q;
    logic             win_open;
    logic [CNT_W-1:0] win_cnt;
    logic             ext_sync;
    logic             preempt;
    logic             gate;

    dma_req_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .done_i    (xfer_done_i),
        .mode_i    (mode_i),
        .bw_code_i (bw_code_i),
        .active_o  (active),
        .mode_o    (mode_q),
        .bw_code_o (bw_q)
    );

    dma_req_window #(.WINDOW_LEN(WINDOW_LEN)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (active),
        .bw_code_i (bw_q),
        .open_o    (win_open),
        .cnt_o     (win_cnt)
    );

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ext_req_i),
        .q_o   (ext_sync)
    );

    // Mode-dependent request gate.
    always_comb begin
        case (mode_q)
            REQ_FULL:  gate = 1'b1;
            REQ_LIMIT: gate = win_open;
            REQ_EXT:   gate = ext_sync;
            default:   gate = 1'b0;
        endcase
    end

    // Preemption, request and transfer strobe.
    always_comb begin
        preempt   = ext_master_req_i | (irq_pending_i & irq_preempt_en_i);
        bus_req_o = active & gate & ~preempt;
        xfer_ok_o = bus_req_o & bus_owned_i;
    end
endmodule

// File: rtl/dma_req_gen_chk.sv
// Module: property checker for dma_req_gen, attached by bind below.
module dma_req_gen_chk
    import dma_req_pkg::*;
#(
    parameter int WINDOW_LEN  = 1024,
    localparam int CNT_W      = $clog2(WINDOW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ext_req_i,
    input  logic             ext_master_req_i,
    input  logic             irq_pending_i,
    input  logic             irq_preempt_en_i,
    input  logic             bus_owned_i,
    input  logic             xfer_done_i,
    input  logic             bus_req_o,
    input  logic             xfer_ok_o,
    input  req_mode_e        mode_q,
    input  logic [1:0]       bw_q,
    input  logic [CNT_W-1:0] win_cnt
);
    localparam int EIGHTH = WINDOW_LEN / 8;

    // R2
    ok_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ok_o |-> (bus_req_o && bus_owned_i));

    // R4
    preempt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_master_req_i || (irq_pending_i && irq_preempt_en_i)) |-> !bus_req_o);

    // R9
    stop_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !bus_req_o);

    // R9
    done_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_i |=> !bus_req_o);

    // R5
    limit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == REQ_LIMIT && bus_req_o) |->
            (int'(win_cnt) < EIGHTH * bw_eighths(bw_q)));

    // R7
    ext_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == REQ_EXT && bus_req_o) |-> $past(ext_req_i, 2));

    // R10
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == REQ_NONE) |-> !bus_req_o);
endmodule

bind dma_req_gen dma_req_gen_chk #(.WINDOW_LEN(WINDOW_LEN)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .ext_req_i        (ext_req_i),
    .ext_master_req_i (ext_master_req_i),
    .irq_pending_i    (irq_pending_i),
    .irq_preempt_en_i (irq_preempt_en_i),
    .bus_owned_i      (bus_owned_i),
    .xfer_done_i      (xfer_done_i),
    .bus_req_o        (bus_req_o),
    .xfer_ok_o        (xfer_ok_o),
    .mode_q           (mode_q),
    .bw_q             (bw_q),
    .win_cnt          (win_cnt)
);

// File: tb/dma_req_gen_tb_top.sv
// Bench for dma_req_gen: sweeps of every mode and code, expected values
// computed arithmetically. Inputs driven at negedge, outputs sampled 1
// time unit later.
module dma_req_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [1:0] bw_code_i = 2'b00;
    logic       ext_req_i = 1'b0;
    logic       ext_master_req_i = 1'b0;
    logic       irq_pending_i = 1'b0;
    logic       irq_preempt_en_i = 1'b0;
    logic       bus_owned_i = 1'b0;
    logic       xfer_done_i = 1'b0;
    logic       bus_req_o;
    logic       xfer_ok_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_gen #(.WINDOW_LEN(WIN)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .mode_i           (mode_i),
        .bw_code_i        (bw_code_i),
        .ext_req_i        (ext_req_i),
        .ext_master_req_i (ext_master_req_i),
        .irq_pending_i    (irq_pending_i),
        .irq_preempt_en_i (irq_preempt_en_i),
        .bus_owned_i      (bus_owned_i),
        .xfer_done_i      (xfer_done_i),
        .bus_req_o        (bus_req_o),
        .xfer_ok_o        (xfer_ok_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic stop_run();
        @(negedge clk);
        start_i = 1'b0; ext_master_req_i = 1'b0; irq_pending_i = 1'b0;
        bus_owned_i = 1'b0; ext_req_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Limited-rate sweep over a little more than two windows (R5, R6, R8, R2).
    task automatic limit_sweep(input logic [1:0] code, input logic [1:0] later, input bit noise);
        int n_allot, bad_req, bad_ok, first_k, first_act, first_exp;
        n_allot = (WIN / 8) * ((code == 2'd0) ? 1 : (code == 2'd1) ? 2 : (code == 2'd2) ? 4 : 6);
        bad_req = 0; bad_ok = 0; first_k = -1; first_act = 0; first_exp = 0;
        @(negedge clk);
        mode_i = 2'b01; bw_code_i = code; start_i = 1'b1; bus_owned_i = 1'b1;
        for (int k = 0; k < 2 * WIN + 20; k++) begin
            bit pre, own, e_req;
            @(negedge clk);
            pre = noise && ((k % 37) < 5);
            own = !(noise && ((k % 3) == 0));
            ext_master_req_i = pre;
            bus_owned_i = own;
            if (k == 5) begin bw_code_i = later; mode_i = 2'b11; end
            #1;
            e_req = ((k % WIN) < n_allot) && !pre;
            if (bus_req_o != e_req) begin
                bad_req++;
                if (first_k < 0) begin first_k = k; first_act = bus_req_o; first_exp = e_req; end
            end
            if (xfer_ok_o != (e_req && own)) bad_ok++;
        end
        if (first_k >= 0) $display("  first mismatch at active cycle %0d: req %0d vs %0d", first_k, first_act, first_exp);
        chk(noise ? "R6" : "R5", $sformatf("limit code %0d req mismatches", code), bad_req, 0);
        chk("R2", $sformatf("limit code %0d strobe mismatches", code), bad_ok, 0);
        stop_run();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and no request before start.
        settle();
        chk("R1", "bus_req after reset", bus_req_o, 0);
        chk("R1", "xfer_ok after reset", xfer_ok_o, 0);
        mode_i = 2'b00; bus_owned_i = 1'b1;
        repeat (4) settle();
        chk("R1", "bus_req with start low", bus_req_o, 0);

        // R3/R4/R8: full-rate with preemption patterns, mode changed mid-run.
        begin
            int bad;
            bad = 0;
            @(negedge clk);
            mode_i = 2'b00; start_i = 1'b1; bus_owned_i = 1'b1;
            for (int k = 0; k < 200; k++) begin
                bit em, irq, en, e;
                @(negedge clk);
                em = (k % 11) == 3;
                irq = (k % 7) < 2;
                en = k >= 100;
                ext_master_req_i = em; irq_pending_i = irq; irq_preempt_en_i = en;
                if (k == 50) mode_i = 2'b11;
                #1;
                e = !(em || (irq && en));
                if (bus_req_o != e) bad++;
            end
            chk("R3", "full-rate request mismatches", bad, 0);
            @(negedge clk);
            ext_master_req_i = 1'b0; irq_pending_i = 1'b1; irq_preempt_en_i = 1'b0;
            #1;
            chk("R4", "irq with enable off", bus_req_o, 1);
            irq_preempt_en_i = 1'b1;
            #1;
            chk("R4", "irq with enable on", bus_req_o, 0);
            irq_pending_i = 1'b0;
            #1;
            chk("R8", "mode change ignored", bus_req_o, 1);
            // R9: clearing start drops the request one edge later.
            @(negedge clk);
            start_i = 1'b0;
            #1;
            chk("R9", "request before edge", bus_req_o, 1);
            settle();
            chk("R9", "request after stop", bus_req_o, 0);
            stop_run();
        end

        // R5/R6/R8/R2: every bandwidth code, clean and disturbed.
        for (int c = 0; c < 4; c++) limit_sweep(2'(c), 2'(3 - c), 1'b0);
        for (int c = 0; c < 4; c++) limit_sweep(2'(c), 2'(c ^ 1), 1'b1);

        // R7: external mode, two-edge latency on a pseudo-random pattern.
        begin
            int bad;
            bit p1, p2;
            bad = 0; p1 = 0; p2 = 0;
            @(negedge clk);
            mode_i = 2'b10; start_i = 1'b1; bus_owned_i = 1'b1; ext_req_i = 1'b0;
            for (int k = 0; k < 300; k++) begin
                bit e;
                settle();
                if (bus_req_o != p2) bad++;
                e = ((k * 7) % 13) < 6;
                p2 = p1; p1 = e;
                ext_req_i = e;
            end
            chk("R7", "external request mismatches", bad, 0);
            stop_run();
        end

        // R10: reserved mode never requests.
        begin
            int hits;
            hits = 0;
            @(negedge clk);
            mode_i = 2'b11; start_i = 1'b1; ext_req_i = 1'b1; bus_owned_i = 1'b1;
            for (int k = 0; k < 50; k++) begin
                settle();
                if (bus_req_o) hits++;
            end
            chk("R10", "reserved mode requests", hits, 0);
            stop_run();
        end

        // R9: completion drops the request, holds it low, restart reopens window.
        @(negedge clk);
        mode_i = 2'b01; bw_code_i = 2'b00; start_i = 1'b1; bus_owned_i = 1'b1;
        repeat (10) @(negedge clk);
        xfer_done_i = 1'b1;
        #1;
        chk("R9", "request before done edge", bus_req_o, 1);
        settle();
        xfer_done_i = 1'b0;
        chk("R9", "request after done", bus_req_o, 0);
        repeat (200) @(negedge clk);
        #1;
        chk("R9", "stays low after done", bus_req_o, 0);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 140; k++) begin
                settle();
                if (bus_req_o != (k < WIN / 8)) bad++;
            end
            chk("R9", "window after restart mismatches", bad, 0);
        end
        stop_run();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule